// File: doc/BRIEF.md
# Prescaled Reference Divider

This block turns a reference clock into a slower comparison pulse for a phase detector. A fixed divide-by-4 prescaler steps a programmable down-counter. The overall division ratio is therefore four times the count value. Because of this, the ratio only moves in steps of four. The count value comes from an already-latched configuration word; the serial path that fills that word sits outside the block. On each terminal count the block raises `fr_o` for one reference-clock period. The same pulse serves as the direct divided output and as the phase detector's reference input.

A parameter picks one of two counter widths. The wide variant has a 14-bit count, giving overall ratios of 20 to 65532. The narrow variant has an 11-bit count, giving ratios of 20 to 8188. Count values below 5 are raised to 5, so the overall ratio never drops below 20. A new count is only picked up when the counter reloads, which means an output period already in progress always completes at its old length. A synchronous reset clears the prescaler, the counter and the output.

Top module: `refdiv_top`

## Requirements
- R1: After reset is released, the first rising clock edge with `rst_i` low counts as edge 1. The first `fr_o` pulse goes high after edge 4*(N+1), where N is the effective count taken from `ratio_i`.
- R2: `fr_o` is high for exactly one clock cycle per output period.
- R3: Once running, successive `fr_o` pulses are exactly 4*N clock cycles apart.
- R4: A `ratio_i` value of 0 to 4 behaves as 5, giving an output period of 20 cycles; values of 5 or more are used as given.
- R5: `ratio_i` is sampled only at the reload edge, which is the edge that raises `fr_o`. A change between two pulses leaves the current period unchanged and sets the length of the following one.
- R6: With `WIDE_VARIANT` = 1, `ratio_i` is 14 bits wide and the largest value 16383 divides by 65532 with no truncation.
- R7: With `WIDE_VARIANT` = 0, `ratio_i` is 11 bits wide and the largest value 2047 divides by 8188.
- R8: While `rst_i` is high at a clock edge, `fr_o` is low after that edge. A reset in the middle of a period restarts the timing of R1.
- R9: The counter changes state at most once every four clock cycles, only on a prescaler tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 14 (wide) or 11 (narrow) | Latched count value N; overall ratio is 4*N |
| fr_o | output | 1 | One-cycle comparison pulse per divided period |

## Verification
On every cycle the assertions check the following. The counter moves only on prescaler ticks, and ticks are never back to back. A pulse follows exactly when a tick meets a count of one, and never otherwise. A pulse lasts one cycle. Every reload lands at or above the floor of 5. The assertions cannot show end-to-end period lengths, the sampling point of a new ratio, the first-period timing after reset, or the two width variants at their maximum counts. The bench shows these by measuring the spacing of `fr_o` pulses while ratios are changed at chosen points.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   localparam int PRESCALE  = 4;
   localparam int MIN_COUNT = 5;
   localparam int WIDE_W    = 14;
   localparam int NARROW_W  = 11;

   function automatic int cnt_width(input bit wide);
      return wide ? WIDE_W : NARROW_W;
   endfunction

endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
      $error("refdiv_prescale: DIV must be a power of two of at least 2");
   end

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) phase_q <= '0;
      else       phase_q <= phase_q + PW'(1);
   end

   assign tick_o = (phase_q == LAST);

endmodule

// File: rtl/refdiv_clamp.sv
module refdiv_clamp #(
   parameter int W   = 14,
   parameter int MIN = 5
) (
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] val_o
);
   if (MIN < 0 || MIN >= (1 << W)) begin : g_bad_min
      $error("refdiv_clamp: MIN does not fit in W bits");
   end

   if (MIN == 0) begin : g_pass
      assign val_o = raw_i;
   end else begin : g_floor
      localparam logic [W-1:0] FLOOR = W'(MIN);
      assign val_o = (raw_i < FLOOR) ? FLOOR : raw_i;
   end

endmodule

// File: rtl/refdiv_downcnt.sv
module refdiv_downcnt #(
   parameter int W = 14
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         step_i,
   input  logic [W-1:0] load_i,
   output logic [W-1:0] cnt_o,
   output logic         term_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         at_end;

   // a count of zero only exists right after reset and reloads at once
   assign at_end = (cnt_q <= ONE);

   always_ff @(posedge clk_i) begin
      if (rst_i)            cnt_q <= '0;
      else if (step_i) begin
         if (at_end)        cnt_q <= load_i;
         else               cnt_q <= cnt_q - ONE;
      end
   end

   assign cnt_o  = cnt_q;
   assign term_o = step_i && (cnt_q == ONE);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
   parameter bit WIDE_VARIANT = 1'b1,
   parameter int PRE_DIV      = refdiv_pkg::PRESCALE,
   parameter int MIN_CNT      = refdiv_pkg::MIN_COUNT
) (
   input  logic                                            clk_i,
   input  logic                                            rst_i,
   input  logic [refdiv_pkg::cnt_width(WIDE_VARIANT)-1:0] ratio_i,
   output logic                                            fr_o
);
   localparam int CNT_W   = refdiv_pkg::cnt_width(WIDE_VARIANT);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (MIN_CNT < 2 || MIN_CNT > CNT_MAX) begin : g_bad_floor
      $error("refdiv_top: MIN_CNT must lie between 2 and the counter maximum");
   end

   logic             pre_tick;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic             term;
   logic             fr_q;

   refdiv_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_o (pre_tick)
   );

   refdiv_clamp #(.W(CNT_W), .MIN(MIN_CNT)) u_clamp (
      .raw_i (ratio_i),
      .val_o (load_val)
   );

   refdiv_downcnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (pre_tick),
      .load_i (load_val),
      .cnt_o  (cnt_q),
      .term_o (term)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) fr_q <= 1'b0;
      else       fr_q <= term;
   end

   assign fr_o = fr_q;

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
   parameter int CNT_W   = 14,
   parameter int MIN_CNT = 5
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             tick_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic             fr_i
);

   p_fr_one_cycle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      fr_i |=> !fr_i);

   p_pulse_at_terminal_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && cnt_i == CNT_W'(1)) |=> fr_i);

   p_no_stray_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !(tick_i && cnt_i == CNT_W'(1)) |=> !fr_i);

   p_step_down_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && cnt_i > CNT_W'(1)) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

   p_reload_floor_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && cnt_i <= CNT_W'(1)) |=> (cnt_i >= CNT_W'(MIN_CNT)));

   p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick_i |=> $stable(cnt_i));

   p_tick_sparse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_i |=> !tick_i);

endmodule

bind refdiv_top refdiv_chk #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .tick_i (pre_tick),
   .cnt_i  (cnt_q),
   .fr_i   (fr_o)
);

// File: tb/refdiv_top_tb_top.sv
`timescale 1ns/1ps
module refdiv_top_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [13:0] ratio_w;
   logic [10:0] ratio_n;
   logic        fr_w;
   logic        fr_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   refdiv_top #(.WIDE_VARIANT(1'b1)) dut_i (
      .clk_i (clk), .rst_i (rst), .ratio_i (ratio_w), .fr_o (fr_w));

   refdiv_top #(.WIDE_VARIANT(1'b0)) dut_narrow_i (
      .clk_i (clk), .rst_i (rst), .ratio_i (ratio_n), .fr_o (fr_n));

   function automatic int eff(input int r);
      return (r < 5) ? 5 : r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   // counts negedges from 'start' until the selected output is seen high
   task automatic next_pulse(input bit narrow, input int start, output int gap);
      gap = start;
      do begin
         @(negedge clk);
         gap++;
         if (gap > 70000) begin
            check(1'b0, "watchdog", gap, 0);
            finish_run();
         end
      end while (!(narrow ? fr_n : fr_w));
   endtask

   task automatic pulse_ends(input bit narrow, input string req);
      @(negedge clk);
      check((narrow ? fr_n : fr_w) == 1'b0, req, int'(narrow ? fr_n : fr_w), 0);
   endtask

   task automatic do_reset(input int w, input int n);
      @(negedge clk);
      rst = 1'b1;
      ratio_w = 14'(w);
      ratio_n = 11'(n);
      repeat (3) @(negedge clk);
      check(fr_w == 1'b0 && fr_n == 1'b0, "R8 reset state", int'(fr_w) + int'(fr_n), 0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      check(1'b0, "watchdog", 180000, 0);
      finish_run();
   end

   initial begin
      int gap;
      int prev;
      int seq [6] = '{0, 3, 4, 5, 6, 9};
      void'($urandom(32'd20240611));
      rst = 1'b1;
      ratio_w = '0;
      ratio_n = '0;

      // R1/R3: first period after reset, then steady spacing
      do_reset(10, 5);
      next_pulse(1'b0, 0, gap);
      check(gap == 4 * 11, "R1 first pulse", gap, 44);
      pulse_ends(1'b0, "R2 width");
      next_pulse(1'b0, 1, gap);
      check(gap == 40, "R3 steady period", gap, 40);

      // R4/R5: floor clamp, new value applied one period late
      prev = 10;
      foreach (seq[i]) begin
         pulse_ends(1'b0, "R2 width");
         ratio_w = 14'(seq[i]);
         next_pulse(1'b0, 1, gap);
         check(gap == 4 * eff(prev), "R4 clamp / R5 late apply", gap, 4 * eff(prev));
         prev = seq[i];
      end

      // R5 random: value changed twice inside one period, last one wins
      for (int it = 0; it < 25; it++) begin
         int a = $urandom_range(300);
         int b = $urandom_range(300);
         int w = $urandom_range(4 * eff(prev) - 3);
         pulse_ends(1'b0, "R2 width");
         ratio_w = 14'(a);
         repeat (w) @(negedge clk);
         ratio_w = 14'(b);
         next_pulse(1'b0, 1 + w, gap);
         check(gap == 4 * eff(prev), "R5 sample at reload", gap, 4 * eff(prev));
         prev = b;
      end
      pulse_ends(1'b0, "R2 width");
      next_pulse(1'b0, 1, gap);
      check(gap == 4 * eff(prev), "R3 period after random", gap, 4 * eff(prev));

      // R8: reset in the middle of a period restarts R1 timing
      repeat (7) @(negedge clk);
      do_reset(7, 5);
      next_pulse(1'b0, 0, gap);
      check(gap == 32, "R8 restart first pulse", gap, 32);
      pulse_ends(1'b0, "R2 width");
      next_pulse(1'b0, 1, gap);
      check(gap == 28, "R8 restart period", gap, 28);

      // R6: wide maximum count
      do_reset(16383, 5);
      next_pulse(1'b0, 0, gap);
      check(gap == 4 * 16384, "R6 wide max", gap, 4 * 16384);
      pulse_ends(1'b0, "R2 width");

      // R7: narrow maximum count
      do_reset(5, 2047);
      next_pulse(1'b1, 0, gap);
      check(gap == 4 * 2048, "R7 narrow first", gap, 4 * 2048);
      pulse_ends(1'b1, "R2 narrow width");
      next_pulse(1'b1, 1, gap);
      check(gap == 8188, "R7 narrow max period", gap, 8188);

      finish_run();
   end

endmodule